// File: doc/BRIEF.md
# Weighted Pseudo-Random Test Pattern Source

This block produces parallel test vectors for a circuit under test in which each vector bit is 1 with a programmable probability instead of the even odds of a raw shift-register bit. A 16-bit maximal-length shift register with linear feedback is the only source of randomness. Every output bit reads its own group of four register bits. It ANDs the first one to four of them and may then complement the result. This gives ones-probabilities of 1/2, 1/4, 3/4, 1/8, 7/8, 1/16 and 15/16. Deep AND gates and wide OR gates in the circuit under test need such skewed inputs. With unbiased bits, a stuck-at-0 on the output of an 8-input AND is exercised only about once in 256 patterns.

The weight codes are arranged in a small bank of sets that is fixed at build time by a parameter. A select input switches between the sets while a test runs. The switch leaves the register sequence alone, so one seeded run can pass through several weightings. A seed-load input restarts the sequence from a chosen state. An enable input advances the sequence by one pattern per clock.

Top module: `wprpg_top`

## Requirements
- R1: After reset the register holds RESET_SEED (default 16'hACE1), set 0 is active, and `vec_o` shows the set-0 weighting of that state.
- R2: With `en_i` high and `seed_load_i` low, each clock shifts the register one place toward its MSB and puts into bit 0 the XOR of bits 15, 13, 12 and 10. This is the polynomial x^16+x^14+x^13+x^11+1.
- R3: With `en_i` and `seed_load_i` both low, the register state and, for an unchanged set, `vec_o` stay as they are.
- R4: `seed_load_i` high loads `seed_i` into the register on the next clock and overrides `en_i`.
- R5: A zero `seed_i` loads RESET_SEED instead, so the register never holds all zeros.
- R6: Output bit j reads register bits 4j..4j+3. Its 3-bit weight code has the invert flag in bit 2 and the depth d in bits 1:0. The bit is the AND of register bits 4j..4j+d, complemented when the invert flag is 1. Set s, bit j sits at WT_BANK[(s*NBITS+j)*3 +: 3].
- R7: A `set_sel_i` value below NSETS becomes the active set on the next clock edge. The change does not reseed or step the register.
- R8: A `set_sel_i` value of NSETS or more is ignored, and the active set stays as it was.
- R9: Over thousands of enabled cycles, the fraction of ones on each output bit is close to 2^-(d+1) when not inverted and close to 1-2^-(d+1) when inverted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Advance the pattern sequence by one step |
| seed_load_i | input | 1 | Load `seed_i` into the register |
| seed_i | input | 16 | Seed value; zero selects RESET_SEED |
| set_sel_i | input | SEL_W | Weight-set select, registered |
| vec_o | output | NBITS | Weighted test vector |

## Verification
On every cycle, the assertions check the register transitions: the step with its feedback taps, the hold, the seed load and the zero-seed substitution. They also check that the active set follows valid selects and ignores invalid ones. The mapping from register state and weight code to output bits is not checked that way. The bench's own model checks it pattern by pattern. Only long bench runs can show the skewed ones-fractions that the weights exist to produce.

// File: rtl/wprpg_pkg.sv
package wprpg_pkg;

  localparam int unsigned LFSR_W  = 16;
  localparam int unsigned GROUP_W = 4;   // register bits read per output bit
  localparam int unsigned CODE_W  = 3;   // {invert, depth[1:0]}
  localparam logic [LFSR_W-1:0] DEFAULT_SEED = 16'hACE1;

  typedef struct packed {
    logic       inv;
    logic [1:0] depth;
  } wcode_t;

  // One step of the x^16+x^14+x^13+x^11+1 register, shifting toward the MSB
  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    logic fb;
    fb = s[15] ^ s[13] ^ s[12] ^ s[10];
    return {s[LFSR_W-2:0], fb};
  endfunction

  // AND of the first depth+1 taps, optionally complemented
  function automatic logic shape_bit(input logic [GROUP_W-1:0] taps, input wcode_t c);
    logic a;
    unique case (c.depth)
      2'd0:    a = taps[0];
      2'd1:    a = &taps[1:0];
      2'd2:    a = &taps[2:0];
      default: a = &taps[3:0];
    endcase
    return a ^ c.inv;
  endfunction

endpackage

// File: rtl/wprpg_lfsr.sv
module wprpg_lfsr
  import wprpg_pkg::*;
#(
  parameter logic [LFSR_W-1:0] RESET_SEED = DEFAULT_SEED
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              load_i,
  input  logic [LFSR_W-1:0] seed_i,
  output logic [LFSR_W-1:0] state_o
);

  logic [LFSR_W-1:0] state_q;
  logic [LFSR_W-1:0] seed_safe;

  assign seed_safe = (seed_i == '0) ? RESET_SEED : seed_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RESET_SEED;
    end else if (load_i) begin
      state_q <= seed_safe;
    end else if (en_i) begin
      state_q <= lfsr_step(state_q);
    end
  end

  assign state_o = state_q;

endmodule

// File: rtl/wprpg_setreg.sv
module wprpg_setreg #(
  parameter int unsigned NSETS = 3,
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  output logic [SEL_W-1:0] set_o
);

  logic             sel_valid;
  logic [SEL_W-1:0] set_q;

  assign sel_valid = (32'(sel_i) < NSETS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      set_q <= '0;
    end else if (sel_valid) begin
      set_q <= sel_i;
    end
  end

  assign set_o = set_q;

endmodule

// File: rtl/wprpg_shaper.sv
module wprpg_shaper
  import wprpg_pkg::*;
#(
  parameter int unsigned NBITS = 4,
  parameter int unsigned NSETS = 3,
  parameter int unsigned SEL_W = 2,
  parameter logic [NSETS*NBITS*CODE_W-1:0] WT_BANK = '0
) (
  input  logic [LFSR_W-1:0] state_i,
  input  logic [SEL_W-1:0]  set_i,
  output logic [NBITS-1:0]  vec_o
);

  for (genvar j = 0; j < NBITS; j++) begin : g_bit
    logic [GROUP_W-1:0] taps;
    wcode_t             code;

    for (genvar k = 0; k < GROUP_W; k++) begin : g_tap
      assign taps[k] = state_i[(j*GROUP_W + k) % LFSR_W];
    end

    always_comb begin
      code = wcode_t'(WT_BANK[(int'(set_i)*NBITS + j)*CODE_W +: CODE_W]);
    end

    assign vec_o[j] = shape_bit(taps, code);
  end

endmodule

// File: rtl/wprpg_top.sv
module wprpg_top
  import wprpg_pkg::*;
#(
  parameter int unsigned NBITS = 4,
  parameter int unsigned NSETS = 3,
  parameter int unsigned SEL_W = (NSETS > 1) ? $clog2(NSETS) : 1,
  parameter logic [LFSR_W-1:0] RESET_SEED = DEFAULT_SEED,
  // set 0: all 1/2; set 1: 1/4, 3/4, 1/8, 7/8; set 2: 1/16, 15/16, ~1/2, 1/2
  parameter logic [NSETS*NBITS*CODE_W-1:0] WT_BANK =
    {3'b000, 3'b100, 3'b111, 3'b011,
     3'b110, 3'b010, 3'b101, 3'b001,
     3'b000, 3'b000, 3'b000, 3'b000}
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              seed_load_i,
  input  logic [LFSR_W-1:0] seed_i,
  input  logic [SEL_W-1:0]  set_sel_i,
  output logic [NBITS-1:0]  vec_o
);

  logic [LFSR_W-1:0] lfsr_q;
  logic [SEL_W-1:0]  set_q;

  wprpg_lfsr #(.RESET_SEED(RESET_SEED)) lfsr_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .load_i  (seed_load_i),
    .seed_i  (seed_i),
    .state_o (lfsr_q)
  );

  wprpg_setreg #(.NSETS(NSETS), .SEL_W(SEL_W)) setreg_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (set_sel_i),
    .set_o  (set_q)
  );

  wprpg_shaper #(
    .NBITS   (NBITS),
    .NSETS   (NSETS),
    .SEL_W   (SEL_W),
    .WT_BANK (WT_BANK)
  ) shaper_i (
    .state_i (lfsr_q),
    .set_i   (set_q),
    .vec_o   (vec_o)
  );

endmodule

// File: rtl/wprpg_chk.sv
module wprpg_chk #(
  parameter int unsigned NSETS = 3,
  parameter int unsigned SEL_W = 2,
  parameter logic [15:0] RESET_SEED = 16'hACE1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             seed_load_i,
  input logic [15:0]      seed_i,
  input logic [SEL_W-1:0] set_sel_i,
  input logic [15:0]      lfsr_q,
  input logic [SEL_W-1:0] set_q
);

  localparam logic [15:0] TAP_MASK = 16'hB400;

  AST_NO_ZERO_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lfsr_q != 16'h0000); // R5

  AST_STEP_POLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !seed_load_i) |=>
      lfsr_q == {$past(lfsr_q[14:0]), ^($past(lfsr_q) & TAP_MASK)}); // R2

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !seed_load_i) |=> $stable(lfsr_q)); // R3

  AST_SEED_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seed_load_i && seed_i != 16'h0000) |=> lfsr_q == $past(seed_i)); // R4

  AST_ZERO_SEED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seed_load_i && seed_i == 16'h0000) |=> lfsr_q == RESET_SEED); // R5

  AST_SET_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(set_sel_i) < NSETS) |=> set_q == $past(set_sel_i)); // R7

  AST_SET_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(set_sel_i) >= NSETS) |=> $stable(set_q)); // R8

endmodule

bind wprpg_top wprpg_chk #(
  .NSETS      (NSETS),
  .SEL_W      (SEL_W),
  .RESET_SEED (RESET_SEED)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en_i),
  .seed_load_i (seed_load_i),
  .seed_i      (seed_i),
  .set_sel_i   (set_sel_i),
  .lfsr_q      (lfsr_q),
  .set_q       (set_q)
);

// File: tb/wprpg_top_tb_top.sv
module wprpg_top_tb_top;

  localparam int NB = 4;
  localparam int NS = 3;
  localparam int SW = 2;
  localparam logic [15:0] RSEED = 16'hACE1;
  // bank restated per set, per bit: {invert, depth}
  localparam logic [2:0] BANK [NS][NB] = '{
    '{3'b000, 3'b000, 3'b000, 3'b000},
    '{3'b001, 3'b101, 3'b010, 3'b110},
    '{3'b011, 3'b111, 3'b100, 3'b000}
  };

  // stimulus table: seed, set, number of enabled steps
  typedef struct packed {
    logic [15:0] seed;
    logic [1:0]  set;
    logic [7:0]  steps;
  } vec_t;
  localparam int NV = 6;
  localparam vec_t TBL [NV] = '{
    '{16'h0001, 2'd0, 8'd40},
    '{16'hFFFF, 2'd1, 8'd40},
    '{16'h8000, 2'd2, 8'd40},
    '{16'h5A5A, 2'd1, 8'd60},
    '{16'h1234, 2'd2, 8'd60},
    '{16'hF00F, 2'd0, 8'd30}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          en;
  logic          load;
  logic [15:0]   seed;
  logic [SW-1:0] sel;
  logic [NB-1:0] vec;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  logic [15:0] m;       // bench model of the register
  int          cur_set;

  always #4 clk = ~clk;

  wprpg_top dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .en_i        (en),
    .seed_load_i (load),
    .seed_i      (seed),
    .set_sel_i   (sel),
    .vec_o       (vec)
  );

  function automatic logic [15:0] model_step(input logic [15:0] s);
    return {s[14:0], ^(s & 16'hB400)};
  endfunction

  function automatic logic [NB-1:0] model_vec(input logic [15:0] s, input int set);
    logic [NB-1:0] v;
    for (int j = 0; j < NB; j++) begin
      logic [2:0] c;
      logic       ones;
      c = BANK[set][j];
      ones = 1'b1;
      for (int k = 0; k <= int'(c[1:0]); k++) ones = ones & s[4*j + k];
      v[j] = c[2] ? ~ones : ones;
    end
    return v;
  endfunction

  task automatic check(input string req, input logic [NB-1:0] exp);
    n_tests++;
    if (vec !== exp) begin
      n_fail++;
      $display("FAIL %s: vec_o=%b expected %b (cycle %0d)", req, vec, exp, cyc);
    end
  endtask

  // drive, wait one edge, update model, sample away from the edge
  task automatic apply(input logic ld, input logic [15:0] sd, input logic e,
                       input logic [SW-1:0] s);
    load = ld; seed = sd; en = e; sel = s;
    @(negedge clk);
    if (ld) m = (sd == 16'h0) ? RSEED : sd;
    else if (e) m = model_step(m);
    if (int'(s) < NS) cur_set = int'(s);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_fail++;
      $display("FAIL watchdog: cycle=%0d expected < %0d", cyc, 150000);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; en = 1'b0; load = 1'b0; seed = '0; sel = '0;
    m = RSEED; cur_set = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 reset state", model_vec(RSEED, 0));
    apply(1'b0, '0, 1'b0, '0);
    check("R1 reset state held", model_vec(RSEED, 0));

    // table walk: load, select, then step with per-pattern model check
    for (int i = 0; i < NV; i++) begin
      apply(1'b1, TBL[i].seed, 1'b1, TBL[i].set);
      check("R4 seed load over enable", model_vec(TBL[i].seed, int'(TBL[i].set)));
      for (int t = 0; t < int'(TBL[i].steps); t++) begin
        apply(1'b0, '0, 1'b1, TBL[i].set);
        check("R2/R6 step and weighting", model_vec(m, cur_set));
      end
    end

    // R3: idle holds the pattern
    apply(1'b1, 16'hBEEF, 1'b0, 2'd1);
    for (int t = 0; t < 5; t++) begin
      apply(1'b0, '0, 1'b0, 2'd1);
      check("R3 idle hold", model_vec(16'hBEEF, 1));
    end

    // R7: set change with enable low shows new weighting of the same state
    apply(1'b0, '0, 1'b0, 2'd2);
    check("R7 set switch no reseed", model_vec(16'hBEEF, 2));
    apply(1'b0, '0, 1'b1, 2'd0);
    check("R7 set switch while stepping", model_vec(model_step(16'hBEEF), 0));

    // R8: out-of-range select ignored
    apply(1'b0, '0, 1'b0, 2'd1);
    apply(1'b0, '0, 1'b0, 2'd3);
    check("R8 invalid select ignored", model_vec(m, 1));
    apply(1'b0, '0, 1'b1, 2'd3);
    check("R8 invalid select while stepping", model_vec(m, 1));

    // R5: zero seed replaced by reset seed
    apply(1'b1, 16'h0000, 1'b0, 2'd0);
    check("R5 zero seed", model_vec(RSEED, 0));
    apply(1'b0, '0, 1'b1, 2'd0);
    check("R5 step after zero seed", model_vec(model_step(RSEED), 0));

    // R9: ones fractions for sets 1 and 2
    for (int s = 1; s < NS; s++) begin
      int cnt [NB];
      int N = 4096;
      for (int j = 0; j < NB; j++) cnt[j] = 0;
      apply(1'b1, 16'h2B3C, 1'b0, SW'(s));
      for (int t = 0; t < N; t++) begin
        apply(1'b0, '0, 1'b1, SW'(s));
        for (int j = 0; j < NB; j++) cnt[j] += int'(vec[j]);
      end
      for (int j = 0; j < NB; j++) begin
        logic [2:0] c;
        int exp_cnt;
        c = BANK[s][j];
        exp_cnt = N >> (int'(c[1:0]) + 1);
        if (c[2]) exp_cnt = N - exp_cnt;
        n_tests++;
        if (cnt[j] < exp_cnt - N/32 || cnt[j] > exp_cnt + N/32) begin
          n_fail++;
          $display("FAIL R9 set %0d bit %0d: ones=%0d expected %0d", s, j, cnt[j], exp_cnt);
        end
      end
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule